// File: doc/BRIEF.md
# Post-Transform Vertex Reuse Cache

This block sits between the stage that fetches vertex indices and the stage that assembles primitives. Each incoming vertex carries an index and a flag saying whether it comes from an indexed draw. For an indexed vertex whose index is still held in the cache, the block reuses the stored transformed record. In that case no work goes to the transform engine. Every other vertex takes a fresh slot and is sent to an external transform engine as a request, tagged with that slot number. The engine may return results in any order. Each result is written into the slot named in the return.

Transformed records leave on the output stream in exactly the order in which their indices were accepted. Reuse is decided only by comparing index tags. Vertices from non-indexed draws never take part in reuse. A draw-start pulse empties the cache, so nothing carries over from one draw to the next. Two running counters report how many accepted vertices were hits and how many were misses.

Top module: `post_xform_vcache`

## Requirements
- R1: An indexed vertex whose index matches a searchable stored tag is accepted without a transform request. Its output record equals the record returned for the earlier vertex with that index.
- R2: A non-indexed vertex always produces a transform request. The slot it takes never matches any later vertex, including an indexed vertex with the same index.
- R3: Only the 18 most recently allocated slots (SLOTS minus INFLIGHT) are searchable. A slot's age is the number of allocations made after it. A slot with age 17 can hit; a slot with age 18 cannot.
- R4: A cycle with `draw_start` high accepts no input and makes every stored tag unsearchable, so the next vertex with a previously seen index misses.
- R5: Misses take slots in round-robin order. After reset the first request carries slot 0, and each later request carries the next slot number, wrapping from 23 to 0. `req_slot` is the 5-bit slot number.
- R6: An indexed vertex that matches a slot whose result has not yet returned counts as a hit and sends no second request. Its output is held until that slot's result arrives.
- R7: Output records leave in input acceptance order whatever the return order. Each output carries the data returned for its slot.
- R8: At most 6 vertices are accepted but not yet output. While 6 are outstanding, `in_ready` is low.
- R9: A missing vertex is accepted only in the cycle its request is accepted (`req_valid` and `req_ready` both high). A hit does not depend on `req_ready`.
- R10: `hit_count` and `miss_count` start at zero after reset. Each accepted vertex adds exactly one to one of them.
- R11: During and right after reset, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| draw_start | input | 1 | One-cycle pulse that empties the cache at a draw boundary |
| in_valid | input | 1 | Incoming vertex is valid |
| in_ready | output | 1 | Block accepts the incoming vertex |
| in_index | input | IDX_W (16) | Vertex index |
| in_indexed | input | 1 | 1 when the vertex comes from an indexed draw |
| req_valid | output | 1 | Transform request valid |
| req_ready | input | 1 | Transform engine accepts the request |
| req_index | output | IDX_W (16) | Index to transform |
| req_slot | output | SLOT_W (5) | Slot the result must be written to |
| res_valid | input | 1 | Transform result valid |
| res_ready | output | 1 | Always high; results are always accepted |
| res_slot | input | SLOT_W (5) | Slot of the returning result |
| res_data | input | DATA_W (32) | Transformed record |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream accepts the record |
| out_data | output | DATA_W (32) | Transformed record, in input order |
| hit_count | output | CNT_W (16) | Number of accepted hits |
| miss_count | output | CNT_W (16) | Number of accepted misses |

## Verification
The assertions assume the following about the environment:
- The transform engine returns each result exactly once, on the slot it was given, and only for requests that are still outstanding.
- `draw_start` is pulsed only when no vertex is outstanding and no result is pending.
- Input and output valids stay high until their handshake completes.

The stimulus keeps within these assumptions:
- The bench's engine model keeps a list of accepted requests and returns only from that list, sometimes out of order and sometimes after long holds.
- The driver issues a draw boundary only after its reference queues have drained.
- The driver and the sink change their signals only after a transfer has been seen.

// File: rtl/vc_pkg.sv
package vc_pkg;

  // Default geometry of the cache.
  localparam int unsigned VC_SLOTS    = 24;
  localparam int unsigned VC_INFLIGHT = 6;

  // Number of allocations made since a slot was written, given the
  // next allocation pointer of a ring of the stated size.
  function automatic int unsigned ring_age(int unsigned next_ptr,
                                           int unsigned slot,
                                           int unsigned ring);
    return (next_ptr + ring - 1 - slot) % ring;
  endfunction

  // A slot may be matched when it is young enough to be in the window.
  function automatic bit in_window(int unsigned age, int unsigned window);
    return age < window;
  endfunction

endpackage

// File: rtl/vc_tag_lookup.sv
module vc_tag_lookup #(
  parameter int SLOTS  = 24,
  parameter int IDX_W  = 16,
  parameter int WINDOW = 18,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic                        lookup_en,
  input  logic [IDX_W-1:0]            lookup_idx,
  input  logic [SLOTS-1:0][IDX_W-1:0] tags,
  input  logic [SLOTS-1:0]            tag_valid,
  input  logic [SLOT_W-1:0]           next_ptr,
  output logic                        hit,
  output logic [SLOT_W-1:0]           hit_slot
);
  import vc_pkg::*;

  logic [SLOTS-1:0] match;

  // One comparator per slot: index equality, valid tag, inside window.
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match[g] = lookup_en && tag_valid[g] && (tags[g] == lookup_idx) &&
                      in_window(ring_age(int'(next_ptr), g, SLOTS), WINDOW);
  end

  // Lowest-numbered match wins; the window allows at most one in practice.
  always_comb begin
    hit      = 1'b0;
    hit_slot = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (match[s]) begin
        hit      = 1'b1;
        hit_slot = SLOT_W'(s);
      end
    end
  end

endmodule

// File: rtl/vc_order_queue.sv
module vc_order_queue #(
  parameter int DEPTH = 6,
  parameter int W     = 5,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;

  function automatic logic [PW-1:0] step(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      if (push) wr_q <= step(wr_q);
      if (pop)  rd_q <= step(rd_q);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/vc_slot_store.sv
module vc_slot_store #(
  parameter int SLOTS  = 24,
  parameter int DATA_W = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_rdy,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  rdy_q;

  // A fresh allocation marks the slot as waiting; a result marks it done.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (wr_en && wr_slot == SLOT_W'(s))
          rdy_q[s] <= 1'b1;
        else if (alloc_en && alloc_slot == SLOT_W'(s))
          rdy_q[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_slot] <= wr_data;
  end

  assign rd_rdy  = rdy_q[rd_slot];
  assign rd_data = data_q[rd_slot];

endmodule

// File: rtl/post_xform_vcache.sv
module post_xform_vcache #(
  parameter int IDX_W    = 16,
  parameter int DATA_W   = 32,
  parameter int SLOTS    = vc_pkg::VC_SLOTS,
  parameter int INFLIGHT = vc_pkg::VC_INFLIGHT,
  parameter int CNT_W    = 16,
  localparam int WINDOW  = SLOTS - INFLIGHT,
  localparam int SLOT_W  = $clog2(SLOTS),
  localparam int QCNT_W  = $clog2(INFLIGHT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              draw_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IDX_W-1:0]  in_index,
  input  logic              in_indexed,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IDX_W-1:0]  req_index,
  output logic [SLOT_W-1:0] req_slot,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [SLOT_W-1:0] res_slot,
  input  logic [DATA_W-1:0] res_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);

  // Tag ring and allocation pointer
  logic [SLOTS-1:0][IDX_W-1:0] tag_q;
  logic [SLOTS-1:0]            tagv_q;
  logic [SLOT_W-1:0]           wp_q;

  // Named internal events
  logic              lookup_hit;
  logic [SLOT_W-1:0] hit_slot;
  logic              accept;
  logic              alloc_fire;
  logic              out_fire;
  logic [SLOT_W-1:0] push_slot;

  // Order queue view
  logic              q_full, q_empty;
  logic [QCNT_W-1:0] q_count;
  logic [SLOT_W-1:0] head_slot;
  logic              head_rdy;
  logic [DATA_W-1:0] head_data;

  vc_tag_lookup #(.SLOTS(SLOTS), .IDX_W(IDX_W), .WINDOW(WINDOW)) u_lookup (
    .lookup_en (in_indexed),
    .lookup_idx(in_index),
    .tags      (tag_q),
    .tag_valid (tagv_q),
    .next_ptr  (wp_q),
    .hit       (lookup_hit),
    .hit_slot  (hit_slot)
  );

  // Acceptance: room in the order queue, no draw boundary, and either a
  // hit or a request the engine takes in the same cycle.
  assign in_ready   = !q_full && !draw_start && (lookup_hit || req_ready);
  assign req_valid  = in_valid && !lookup_hit && !q_full && !draw_start;
  assign req_index  = in_index;
  assign req_slot   = wp_q;
  assign accept     = in_valid && in_ready;
  assign alloc_fire = accept && !lookup_hit;
  assign push_slot  = lookup_hit ? hit_slot : wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q  <= '0;
      tagv_q <= '0;
      wp_q   <= '0;
    end else if (draw_start) begin
      tagv_q <= '0;
    end else if (alloc_fire) begin
      tag_q[wp_q]  <= in_index;
      tagv_q[wp_q] <= in_indexed;
      wp_q         <= (wp_q == SLOT_W'(SLOTS - 1)) ? '0 : wp_q + 1'b1;
    end
  end

  vc_order_queue #(.DEPTH(INFLIGHT), .W(SLOT_W)) u_order (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (accept),
    .push_data(push_slot),
    .pop      (out_fire),
    .head     (head_slot),
    .count    (q_count),
    .full     (q_full),
    .empty    (q_empty)
  );

  vc_slot_store #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_fire),
    .alloc_slot(wp_q),
    .wr_en     (res_valid),
    .wr_slot   (res_slot),
    .wr_data   (res_data),
    .rd_slot   (head_slot),
    .rd_rdy    (head_rdy),
    .rd_data   (head_data)
  );

  assign res_ready = 1'b1;
  assign out_valid = !q_empty && head_rdy;
  assign out_data  = head_data;
  assign out_fire  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else if (accept) begin
      if (lookup_hit) hit_count  <= hit_count + 1'b1;
      else            miss_count <= miss_count + 1'b1;
    end
  end

endmodule

// File: rtl/vc_checker.sv
module vc_checker #(
  parameter int DATA_W   = 32,
  parameter int INFLIGHT = 6,
  parameter int CNT_W    = 16,
  localparam int QCNT_W  = $clog2(INFLIGHT + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              draw_start,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_indexed,
  input logic              req_valid,
  input logic              req_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [CNT_W-1:0]  hit_count,
  input logic [CNT_W-1:0]  miss_count,
  input logic [QCNT_W-1:0] q_count,
  input logic              lookup_hit
);

  // R8: outstanding vertices never exceed the limit
  a_r8_outstanding_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= QCNT_W'(INFLIGHT));

  // R8: a full order queue refuses input
  a_r8_stall_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (q_count == QCNT_W'(INFLIGHT)) |-> !in_ready);

  // R9: a request handshake coincides with the acceptance of a missing vertex
  a_r9_request_with_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> (in_valid && in_ready && !lookup_hit));

  // R2: an accepted non-indexed vertex always goes to the engine
  a_r2_nonindexed_requests: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_indexed) |-> (req_valid && req_ready));

  // R4: no acceptance during a draw boundary
  a_r4_block_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    draw_start |-> !in_ready);

  // R10: each acceptance advances the total by one
  a_r10_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (CNT_W'(hit_count + miss_count) == CNT_W'($past(hit_count) + $past(miss_count) + 1'b1)));

  // R7: a stalled output record stays put
  a_r7_output_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind post_xform_vcache vc_checker #(
  .DATA_W(DATA_W), .INFLIGHT(INFLIGHT), .CNT_W(CNT_W)
) u_vc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .draw_start(draw_start),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_indexed(in_indexed),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .hit_count (hit_count),
  .miss_count(miss_count),
  .q_count   (q_count),
  .lookup_hit(lookup_hit)
);

// File: tb/sim_post_xform_vcache.sv
module sim_post_xform_vcache;
  localparam int IDX_W = 16, DATA_W = 32, SLOTS = 24, INFLIGHT = 6, CNT_W = 16;
  localparam int WIN = SLOTS - INFLIGHT;
  localparam int SLOT_W = $clog2(SLOTS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic draw_start = 0, in_valid = 0, in_indexed = 0, req_ready = 0;
  logic res_valid = 0, out_ready = 0;
  logic [IDX_W-1:0] in_index = '0;
  logic [SLOT_W-1:0] res_slot = '0;
  logic [DATA_W-1:0] res_data = '0;
  logic in_ready, req_valid, res_ready, out_valid;
  logic [IDX_W-1:0] req_index;
  logic [SLOT_W-1:0] req_slot;
  logic [DATA_W-1:0] out_data;
  logic [CNT_W-1:0] hit_count, miss_count;

  always #5 clk = ~clk;

  post_xform_vcache #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SLOTS(SLOTS),
    .INFLIGHT(INFLIGHT), .CNT_W(CNT_W)) u0 (.*);

  int checks = 0, errors = 0;
  int st_idx[$]; bit st_ixd[$]; bit st_drw[$];
  int exp_q[$]; int pend_slot[$]; int pend_idx[$];
  int tags[SLOTS];
  int mwp = 0, m_hits = 0, m_misses = 0, req_cnt = 0;
  bit cur_valid = 0, cur_ixd = 0;
  int cur_idx = 0;
  int rr_mode = 0, or_mode = 0, ret_rand = 0;
  bit hold_ret = 0, running = 0;
  logic [31:0] rs = 32'h1F2E3D4C;

  function automatic logic [DATA_W-1:0] xf(int i);
    logic [31:0] v = i;
    return {v[15:0], ~v[15:0]} ^ 32'h3C5A_96E1;
  endfunction

  task automatic rnd(output int r);
    rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
    r = int'(rs & 32'h7fff_ffff);
  endtask

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: the newest WIN allocations are searchable.
  function automatic int model_lookup(int idx);
    for (int s = 0; s < SLOTS; s++) begin
      int age = (mwp - 1 - s + 2 * SLOTS) % SLOTS;
      if (tags[s] == idx && age < WIN) return s;
    end
    return -1;
  endfunction

  // Driver, engine, sink and reference model in one ordered loop.
  initial begin
    for (int s = 0; s < SLOTS; s++) tags[s] = -1;
    wait (running);
    forever begin
      int r;
      @(negedge clk);
      draw_start = 0;
      if (!cur_valid) begin
        in_valid = 0;
        if (st_idx.size() > 0) begin
          if (st_drw[0]) begin
            if (exp_q.size() == 0 && pend_idx.size() == 0) begin
              draw_start = 1;
              void'(st_idx.pop_front()); void'(st_ixd.pop_front()); void'(st_drw.pop_front());
            end
          end else begin
            cur_idx = st_idx.pop_front(); cur_ixd = st_ixd.pop_front(); void'(st_drw.pop_front());
            cur_valid = 1;
            in_valid = 1; in_index = IDX_W'(cur_idx); in_indexed = cur_ixd;
          end
        end
      end
      rnd(r); req_ready = (rr_mode == 0) ? 1'b1 : r[1];
      rnd(r); out_ready = (or_mode == 0) ? 1'b1 : (or_mode == 2) ? 1'b0 : r[2];
      res_valid = 0;
      rnd(r);
      if (!hold_ret && pend_idx.size() > 0 && (ret_rand == 0 || r[3])) begin
        int k;
        rnd(k);
        k = (ret_rand != 0) ? k % pend_idx.size() : 0;
        res_valid = 1;
        res_slot = SLOT_W'(pend_slot[k]);
        res_data = xf(pend_idx[k]);
        pend_slot.delete(k); pend_idx.delete(k);
      end
      #1;
      // R10: counters track the reference every cycle
      chk(hit_count == CNT_W'(m_hits), "R10", "hit_count", hit_count, m_hits);
      chk(miss_count == CNT_W'(m_misses), "R10", "miss_count", miss_count, m_misses);
      if (exp_q.size() == INFLIGHT)
        chk(in_ready == 0, "R8", "in_ready with queue full", in_ready, 0);
      if (out_valid && exp_q.size() == 0)
        chk(0, "R7", "out_valid with nothing expected", 1, 0);
      if (req_valid && req_ready) begin
        chk(int'(req_slot) == mwp, "R5", "req_slot", req_slot, mwp);
        chk(int'(req_index) == cur_idx, "R9", "req_index", req_index, cur_idx);
        pend_slot.push_back(int'(req_slot)); pend_idx.push_back(int'(req_index));
        req_cnt++;
      end
      if (out_valid && out_ready && exp_q.size() > 0) begin
        chk(out_data == xf(exp_q[0]), "R7", "out_data", out_data, xf(exp_q[0]));
        void'(exp_q.pop_front());
      end
      if (draw_start) for (int s = 0; s < SLOTS; s++) tags[s] = -1;
      if (in_valid && in_ready) begin
        int hs;
        hs = cur_ixd ? model_lookup(cur_idx) : -1;
        if (hs >= 0) begin
          m_hits++;
          chk(!(req_valid && req_ready), "R1", "request on hit", 1, 0);
        end else begin
          m_misses++;
          chk(req_valid && req_ready, cur_ixd ? "R9" : "R2", "request on miss", 0, 1);
          tags[mwp] = cur_ixd ? cur_idx : -1;
          mwp = (mwp + 1) % SLOTS;
        end
        exp_q.push_back(cur_idx);
        cur_valid = 0;
      end
    end
  end

  task automatic send(int idx, bit ixd);
    @(posedge clk);
    st_idx.push_back(idx); st_ixd.push_back(ixd); st_drw.push_back(0);
  endtask

  task automatic new_draw();
    @(posedge clk);
    st_idx.push_back(0); st_ixd.push_back(0); st_drw.push_back(1);
  endtask

  task automatic drain();
    while (st_idx.size() > 0 || cur_valid || exp_q.size() > 0 || pend_idx.size() > 0)
      @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int h0, m0, rq0;
    int strip[12] = '{0, 1, 2, 1, 2, 3, 2, 3, 4, 3, 4, 5};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11, R10: reset state
    chk(out_valid == 0, "R11", "out_valid in reset", out_valid, 0);
    chk(hit_count == 0 && miss_count == 0, "R10", "counters in reset", hit_count + miss_count, 0);
    rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R11", "out_valid after reset", out_valid, 0);
    running = 1;

    // R1: indexed strip with reuse
    h0 = m_hits; m0 = m_misses;
    foreach (strip[i]) send(strip[i], 1);
    drain();
    chk(m_hits - h0 == 6, "R1", "hits on indexed strip", m_hits - h0, 6);
    chk(int'(hit_count) == m_hits, "R1", "hit_count after strip", hit_count, m_hits);

    // R2: same pattern non-indexed, then an indexed repeat still misses
    new_draw();
    h0 = m_hits; m0 = m_misses;
    foreach (strip[i]) send(strip[i], 0);
    send(0, 1);
    drain();
    chk(m_hits - h0 == 0, "R2", "hits on non-indexed", m_hits - h0, 0);
    chk(int'(miss_count) - m0 == 13, "R2", "misses on non-indexed", int'(miss_count) - m0, 13);

    // R3: window edge, age 17 hits, age 18 misses
    new_draw();
    h0 = m_hits; m0 = m_misses;
    for (int i = 0; i < WIN; i++) send(100 + i, 1);
    send(100, 1);
    send(118, 1);
    send(100, 1);
    drain();
    chk(int'(hit_count) - h0 == 1, "R3", "hits at window edge", int'(hit_count) - h0, 1);
    chk(int'(miss_count) - m0 == 20, "R3", "misses at window edge", int'(miss_count) - m0, 20);

    // R4: draw boundary clears
    new_draw();
    send(7, 1);
    new_draw();
    h0 = m_hits;
    send(7, 1);
    drain();
    chk(int'(hit_count) - h0 == 0, "R4", "hit after clear", int'(hit_count) - h0, 0);

    // R6: hit on an in-flight slot
    new_draw();
    drain();
    hold_ret = 1;
    h0 = m_hits; rq0 = req_cnt;
    send(50, 1);
    send(50, 1);
    repeat (12) @(posedge clk);
    @(negedge clk); #2;
    chk(req_cnt - rq0 == 1, "R6", "requests for in-flight pair", req_cnt - rq0, 1);
    chk(int'(hit_count) - h0 == 1, "R6", "in-flight hit counted", int'(hit_count) - h0, 1);
    chk(out_valid == 0, "R6", "output waits for result", out_valid, 0);
    hold_ret = 0;
    drain();

    // R8: stall with the output blocked
    new_draw();
    drain();
    or_mode = 2;
    for (int i = 0; i < 8; i++) send(300 + i, 1);
    repeat (30) @(posedge clk);
    @(negedge clk); #2;
    chk(exp_q.size() == INFLIGHT, "R8", "outstanding count", exp_q.size(), INFLIGHT);
    chk(in_ready == 0, "R8", "in_ready while full", in_ready, 0);
    or_mode = 0;
    drain();

    // R7: random stream, random back-pressure, out-of-order returns
    rr_mode = 1; or_mode = 1; ret_rand = 1;
    for (int i = 0; i < 300; i++) begin
      int r, q;
      rnd(r); rnd(q);
      send(r % 14, (q % 5) != 0);
    end
    drain();
    chk(int'(hit_count) == m_hits, "R7", "final hits", hit_count, m_hits);
    chk(int'(miss_count) == m_misses, "R7", "final misses", miss_count, m_misses);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule